// File: doc/BRIEF.md
# Sampled Wake Event Edge Detector

This block watches one asynchronous wake-up pin in an always-on, low-power domain and turns a clean transition on it into a single-cycle event on the system clock. The pin is first gated by an input enable. A disabled input reads as a constant high inside the block. The gated pin is then brought into the clock domain by a short flop chain. It is sampled only on a slow tick strobe, and the mode field picks which of three tick sources is used. A level reaches the filtered output only after consecutive samples agree. The filtered output therefore rejects short pulses in either direction, and an event fires when it moves toward the selected polarity.

A second path bypasses the sampler. While the clear enable is set, the clear request follows the raw enabled pin and is asserted whenever the pin is at its active level. The request drives the clear of a bank of retention registers without waiting for any clock or tick, and it keeps working when the sampler is switched off.

Top module: `wake_evt_detect`

## Requirements
- R1: While reset is asserted and directly after it, `evt_pulse` is 0 and `filt_level` is 1.
- R2: `ctl_mode` selects the sample strobe: 0 = no sampling, 1 = `tick_slow`, 2 = `tick_mid`, 3 = `tick_fast`. Ticks from unselected sources have no effect.
- R3: With `ctl_polarity` = 0 an event is a high-to-low change of the filtered level, and with `ctl_polarity` = 1 it is a low-to-high change. A change in the other direction produces no event.
- R4: With `ctl_in_en` = 0 the sampled input is forced high, so a low pin produces no event and cannot pull `filt_level` low.
- R5: `filt_level` takes a new value only on a selected tick, and only when that tick and the previous selected tick both sampled the new value. A pulse shorter than one tick period is rejected.
- R6: `evt_pulse` is high for exactly one clock cycle, in the cycle after the clock edge at which `filt_level` changes in the active direction.
- R7: With `ctl_mode` = 0 no event is produced, and `filt_level` follows the inactive level (the inverse of `ctl_polarity`) one cycle later.
- R8: `gp_clear_req` is combinational and equals `ctl_clr_en & ctl_in_en & (wake_pin == ctl_polarity)`, in every mode and without any clock edge.
- R9: The gated pin reaches the sampler through two system-clock flops, so a tick sees the pin value from two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of the always-on domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_pin | input | 1 | Asynchronous wake-up pin |
| ctl_in_en | input | 1 | Input enable; 0 forces the internal input high |
| ctl_polarity | input | 1 | 0 = falling event, 1 = rising event |
| ctl_clr_en | input | 1 | Enables the retention clear request |
| ctl_mode | input | 2 | Sampler mode and tick source select |
| tick_slow | input | 1 | Slowest sample strobe, one clock wide |
| tick_mid | input | 1 | Middle-rate sample strobe |
| tick_fast | input | 1 | Fastest sample strobe |
| evt_pulse | output | 1 | One-cycle event pulse |
| gp_clear_req | output | 1 | Level request that clears the retention registers |
| filt_level | output | 1 | Glitch-filtered input level |

## Verification
The bench uses the default two-flop synchroniser and a two-sample confirmation window. A reference model of that configuration is compared on every cycle. The three tick strobes are compressed to periods of 20, 50 and 130 clock cycles. This keeps every mode, both polarities, sub-period glitches in both directions, the disabled input and the mode-off clear path within a few thousand cycles.

// File: rtl/wev_pkg.sv
package wev_pkg;

  typedef enum logic [1:0] {
    SMP_OFF  = 2'd0,
    SMP_SLOW = 2'd1,
    SMP_MID  = 2'd2,
    SMP_FAST = 2'd3
  } smp_mode_e;

  // level the filter idles at so that enabling never yields an event
  function automatic logic idle_level(input logic pol);
    return ~pol;
  endfunction

  // raw clear condition, independent of any clock
  function automatic logic clear_active(input logic en, input logic clr,
                                        input logic pol, input logic pin);
    return clr & en & (pin == pol);
  endfunction

  // event when the new filtered level equals the active polarity
  function automatic logic is_active_edge(input logic old_lvl, input logic new_lvl,
                                          input logic pol);
    return (old_lvl != new_lvl) && (new_lvl == pol);
  endfunction

endpackage

// File: rtl/wev_sync.sv
module wev_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wev_tick_sel.sv
module wev_tick_sel
  import wev_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       tick_slow,
  input  logic       tick_mid,
  input  logic       tick_fast,
  output logic       run,
  output logic       samp_tick
);
  smp_mode_e m;
  assign m = smp_mode_e'(mode);

  always_comb begin
    unique case (m)
      SMP_SLOW: samp_tick = tick_slow;
      SMP_MID:  samp_tick = tick_mid;
      SMP_FAST: samp_tick = tick_fast;
      default:  samp_tick = 1'b0;
    endcase
  end

  assign run = (m != SMP_OFF);
endmodule

// File: rtl/wev_filter.sv
module wev_filter
  import wev_pkg::*;
#(
  parameter int CONFIRM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic samp_tick,
  input  logic din,
  input  logic pol,
  output logic filt,
  output logic accept,
  output logic new_lvl
);
  localparam int HW = CONFIRM - 1;

  logic [HW-1:0]      hist;
  logic [CONFIRM-1:0] window;
  logic               all_hi, all_lo;

  assign window  = {hist, din};
  assign all_hi  = &window;
  assign all_lo  = ~|window;
  assign new_lvl = all_hi;
  assign accept  = run && samp_tick && (all_hi || all_lo) && (all_hi != filt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= {HW{1'b1}};
      filt <= 1'b1;
    end else if (!run) begin
      hist <= {HW{idle_level(pol)}};
      filt <= idle_level(pol);
    end else if (samp_tick) begin
      hist <= window[HW-1:0];
      if (accept) filt <= new_lvl;
    end
  end
endmodule

// File: rtl/wake_evt_detect.sv
module wake_evt_detect
  import wev_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int CONFIRM_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_pin,
  input  logic       ctl_in_en,
  input  logic       ctl_polarity,
  input  logic       ctl_clr_en,
  input  logic [1:0] ctl_mode,
  input  logic       tick_slow,
  input  logic       tick_mid,
  input  logic       tick_fast,
  output logic       evt_pulse,
  output logic       gp_clear_req,
  output logic       filt_level
);
  logic gated_pin;
  logic synced;
  logic run;
  logic samp_tick;
  logic accept;
  logic new_lvl;
  logic edge_hit;

  assign gated_pin = ctl_in_en ? wake_pin : 1'b1;

  wev_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gated_pin), .q(synced)
  );

  wev_tick_sel u_tick (
    .mode(ctl_mode), .tick_slow(tick_slow), .tick_mid(tick_mid),
    .tick_fast(tick_fast), .run(run), .samp_tick(samp_tick)
  );

  wev_filter #(.CONFIRM(CONFIRM_TICKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .run(run), .samp_tick(samp_tick),
    .din(synced), .pol(ctl_polarity), .filt(filt_level),
    .accept(accept), .new_lvl(new_lvl)
  );

  assign edge_hit = accept && is_active_edge(filt_level, new_lvl, ctl_polarity);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_pulse <= 1'b0;
    else        evt_pulse <= edge_hit;
  end

  assign gp_clear_req = clear_active(ctl_in_en, ctl_clr_en, ctl_polarity, wake_pin);
endmodule

// File: rtl/wev_checker.sv
module wev_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctl_mode,
  input logic       ctl_polarity,
  input logic       ctl_clr_en,
  input logic       samp_tick,
  input logic       evt_pulse,
  input logic       filt_level,
  input logic       gp_clear_req
);
  // R6
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse);

  // R7
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode == 2'd0) |=> !evt_pulse);

  // R5
  filt_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_tick && ctl_mode != 2'd0) |=> $stable(filt_level));

  // R3
  evt_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (filt_level == $past(ctl_polarity)));

  // R8
  clr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_clr_en |-> !gp_clear_req);
endmodule

bind wake_evt_detect wev_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .ctl_polarity(ctl_polarity),
  .ctl_clr_en(ctl_clr_en), .samp_tick(samp_tick), .evt_pulse(evt_pulse),
  .filt_level(filt_level), .gp_clear_req(gp_clear_req)
);

// File: tb/wake_evt_detect_test.sv
module wake_evt_detect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_pin = 1'b1, ctl_in_en = 1'b0, ctl_polarity = 1'b0, ctl_clr_en = 1'b0;
  logic [1:0] ctl_mode = 2'd0;
  logic tick_slow = 1'b0, tick_mid = 1'b0, tick_fast = 1'b0;
  logic evt_pulse, gp_clear_req, filt_level;

  int n_checks = 0, n_fail = 0, ev_cnt = 0, cyc = 0;

  always #10 clk = ~clk;

  wake_evt_detect uut (
    .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .ctl_in_en(ctl_in_en),
    .ctl_polarity(ctl_polarity), .ctl_clr_en(ctl_clr_en), .ctl_mode(ctl_mode),
    .tick_slow(tick_slow), .tick_mid(tick_mid), .tick_fast(tick_fast),
    .evt_pulse(evt_pulse), .gp_clear_req(gp_clear_req), .filt_level(filt_level)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: delay queue plus last-sample memory
  logic q_sync[$] = '{1'b1, 1'b1};
  logic m_prev = 1'b1, m_filt = 1'b1, m_evt = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_sync = '{1'b1, 1'b1};
      m_prev = 1'b1; m_filt = 1'b1; m_evt = 1'b0;
    end else begin
      automatic logic s  = q_sync[1];
      automatic logic tk = (ctl_mode == 2'd1) ? tick_slow :
                           (ctl_mode == 2'd2) ? tick_mid  :
                           (ctl_mode == 2'd3) ? tick_fast : 1'b0;
      m_evt = 1'b0;
      if (ctl_mode == 2'd0) begin
        m_filt = ~ctl_polarity; m_prev = ~ctl_polarity;
      end else if (tk) begin
        if (s == m_prev && s != m_filt) begin
          m_filt = s;
          m_evt  = (s == ctl_polarity);
        end
        m_prev = s;
      end
      void'(q_sync.pop_back());
      q_sync.push_front(ctl_in_en ? wake_pin : 1'b1);
    end
  end

  // per-cycle comparison, before the stimulus of this half cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk(evt_pulse == m_evt, "R6/R9 evt_pulse", evt_pulse, m_evt);
      chk(filt_level == m_filt, "R5/R9 filt_level", filt_level, m_filt);
      chk(gp_clear_req == (ctl_clr_en & ctl_in_en & (wake_pin == ctl_polarity)),
          "R8 gp_clear_req", gp_clear_req,
          ctl_clr_en & ctl_in_en & (wake_pin == ctl_polarity));
      if (evt_pulse) ev_cnt++;
    end
  end

  // compressed tick strobes
  always @(negedge clk) begin
    #1;
    cyc++;
    tick_fast = (cyc % 20 == 0);
    tick_mid  = (cyc % 50 == 0);
    tick_slow = (cyc % 130 == 0);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    fork
      begin
        #2;
        wait_cyc(4);
        chk(evt_pulse == 1'b0, "R1 evt in reset", evt_pulse, 0);
        chk(filt_level == 1'b1, "R1 filt in reset", filt_level, 1);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(filt_level == 1'b1, "R1 filt after reset", filt_level, 1);

        // R2 R3: fast mode, falling polarity
        ctl_mode = 2'd3; ctl_in_en = 1'b1; wake_pin = 1'b1;
        wait_cyc(100); ev_cnt = 0;
        wake_pin = 1'b0; wait_cyc(100);
        chk(ev_cnt == 1, "R3 falling event", ev_cnt, 1);
        chk(filt_level == 1'b0, "R3 filt low", filt_level, 0);

        // R5 high glitch shorter than a tick period
        ev_cnt = 0;
        wake_pin = 1'b1; wait_cyc(5); wake_pin = 1'b0; wait_cyc(100);
        chk(ev_cnt == 0, "R5 high glitch", ev_cnt, 0);
        chk(filt_level == 1'b0, "R5 filt held low", filt_level, 0);

        // R3 rising change gives no event with falling polarity
        wake_pin = 1'b1; wait_cyc(100);
        chk(ev_cnt == 0, "R3 rising ignored", ev_cnt, 0);

        // R5 low glitch
        wake_pin = 1'b0; wait_cyc(5); wake_pin = 1'b1; wait_cyc(100);
        chk(ev_cnt == 0, "R5 low glitch", ev_cnt, 0);
        chk(filt_level == 1'b1, "R5 filt held high", filt_level, 1);

        // R3 rising polarity
        ctl_polarity = 1'b1; ev_cnt = 0;
        wake_pin = 1'b0; wait_cyc(100); wake_pin = 1'b1; wait_cyc(100);
        chk(ev_cnt == 1, "R3 rising event", ev_cnt, 1);

        // R4 disabled input forced high
        ctl_polarity = 1'b0; ctl_in_en = 1'b0; ev_cnt = 0;
        wake_pin = 1'b0; wait_cyc(200);
        chk(ev_cnt == 0, "R4 disabled no event", ev_cnt, 0);
        chk(filt_level == 1'b1, "R4 filt forced high", filt_level, 1);

        // R2 middle tick
        ctl_mode = 2'd2; ctl_in_en = 1'b1; wake_pin = 1'b1; wait_cyc(200);
        ev_cnt = 0; wake_pin = 1'b0; wait_cyc(300);
        chk(ev_cnt == 1, "R2 mid-rate event", ev_cnt, 1);
        wake_pin = 1'b1; wait_cyc(300);

        // R2 slow tick
        ctl_mode = 2'd1; ev_cnt = 0; wake_pin = 1'b0; wait_cyc(600);
        chk(ev_cnt == 1, "R2 slow-rate event", ev_cnt, 1);
        wake_pin = 1'b1; wait_cyc(600);

        // R7 sampler off
        ctl_mode = 2'd0; ev_cnt = 0;
        for (int i = 0; i < 3; i++) begin
          wake_pin = 1'b0; wait_cyc(100); wake_pin = 1'b1; wait_cyc(100);
        end
        chk(ev_cnt == 0, "R7 no event when off", ev_cnt, 0);
        chk(filt_level == 1'b1, "R7 idle high", filt_level, 1);
        ctl_polarity = 1'b1; wait_cyc(2);
        chk(filt_level == 1'b0, "R7 idle follows polarity", filt_level, 0);

        // R8 clear request, no clock edge between change and check
        ctl_clr_en = 1'b1; wake_pin = 1'b1; #1;
        chk(gp_clear_req == 1'b1, "R8 active high", gp_clear_req, 1);
        wake_pin = 1'b0; #1;
        chk(gp_clear_req == 1'b0, "R8 inactive", gp_clear_req, 0);
        ctl_polarity = 1'b0; #1;
        chk(gp_clear_req == 1'b1, "R8 active low", gp_clear_req, 1);
        ctl_in_en = 1'b0; #1;
        chk(gp_clear_req == 1'b0, "R8 disabled input", gp_clear_req, 0);
        ctl_in_en = 1'b1; ctl_clr_en = 1'b0; #1;
        chk(gp_clear_req == 1'b0, "R8 clear disabled", gp_clear_req, 0);
        wait_cyc(10);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule